// File: doc/BRIEF.md
# System Control Register Bank

This block holds the privileged processor-control registers that a CPU reaches with coprocessor move commands. Each command names a primary register (CRn), a secondary field (CRm), two opcode fields and a privilege flag, and carries a 32-bit value when it writes. A legality checker accepts or rejects every command. An accepted write is shaped by that register's write mask. An accepted read returns the stored contents or a fixed identification value.

Two register sets exist. The opcode_2 = 0 set holds the main control state. The opcode_2 ≠ 0 set holds the cache-type constant and an auxiliary control register. Register 14 also reaches four debug registers, picked by CRm. Bit 7 of the control register drives an endianness output. Whenever a write flips that bit, a one-cycle change-mode pulse is raised.

Commands use a valid/ready handshake. The accept/reject status and the read data appear combinationally in the same cycle as the command. Writes take effect at the next clock edge.

Top module: `sysctl_regbank`

## Requirements
- R1: A command is rejected when cmd_priv is 0 (user mode) or when cmd_op1 is non-zero, whatever the other fields hold.
- R2: With privilege and op1 = 0, legality is decided per CRn as follows. CRn 0 and 1 need CRm = 0 and take any op2. CRn 2, 3, 5, 6 and 13 need CRm = 0 and op2 = 0. CRn 8 accepts op2 = 0 with CRm 5..7, and op2 = 1 with CRm 5 or 6. CRn 9 and 10 need CRm in {0,1} and op2 in {0,1}. CRn 15 needs CRm = 1 and op2 = 0. CRn 4, 11 and 12 always reject.
- R3: CRn 7 is accepted only for these (op2, CRm) pairs: (0,5), (0,6), (0,7), (1,5), (1,6), (1,10), (4,10), (5,2), (6,5).
- R4: CRn 0 with op2 = 0 reads the constant 0x69052000. CRn 0 with op2 ≠ 0 reads the constant 0x0B1AA1AA. Writes to either leave the read value unchanged.
- R5: The control register (CRn 1, op2 = 0) reads 0x00000078 after reset. A write stores (value AND 0x00003B87) OR 0x00000078.
- R6: big_endian equals bit 7 of the control register and is 0 after reset. mode_pulse is high for exactly the one cycle after any write that changes that bit, and low otherwise.
- R7: In the op2 = 0 set, writes keep only these bits: CRn 2 keeps 0xFFFFC000, CRn 5 keeps 0x000006FF, CRn 9 keeps 0x1, CRn 13 keeps 0xFE000000 and CRn 15 keeps 0x00003FFF. CRn 3 and 6 keep all 32 bits. Writes to CRn 7, 8 and 10 are discarded, and those registers read 0.
- R8: In CRn 14 (op2 = 0), CRm 3, 4, 8 and 9 each select their own fully writable debug register for both reads and writes. CRm 0 selects a separate shared fully writable slot.
- R9: cmd_ready is 0 during reset and 1 afterwards. rsp_ok and rsp_rdata are valid combinationally in the cycle of cmd_valid. rsp_rdata is 0 for writes. A read returns the contents held before any write in the same cycle.
- R10: A rejected command changes no state and returns rsp_rdata = 0.
- R11: In the op2 ≠ 0 set, CRn 1 is an auxiliary register that keeps write bits 0x33 and resets to 0. Every other CRn in that set, apart from CRn 0, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_priv | input | 1 | 1 = privileged requester, 0 = user mode |
| cmd_crn | input | 4 | Primary register number |
| cmd_crm | input | 4 | Secondary register field |
| cmd_op1 | input | 3 | opcode_1 field |
| cmd_op2 | input | 3 | opcode_2 field, selects register set |
| cmd_wdata | input | 32 | Write value |
| cmd_ready | output | 1 | Bank can take a command |
| rsp_ok | output | 1 | Command accepted (same cycle) |
| rsp_rdata | output | 32 | Read data (same cycle) |
| big_endian | output | 1 | Endianness control from control register bit 7 |
| mode_pulse | output | 1 | One-cycle pulse after an endianness change |

## Verification
The bench sweeps every CRn/CRm/op2 combination in a privileged read and compares acceptance and data against a behavioural model. A checker that confuses the register-7 pair table or the CRn 14 CRm list would accept or reject the wrong combinations. The bench writes all ones into each masked register and reads it back, which shows a wrong mask or a missing forced-one field in the control register as a wrong read value. It rewrites the control register with an unchanged endianness bit, which catches a pulse that fires on every write rather than on every change. It also reads back after rejected writes and after writes to the constant and discarded registers, which exposes any state that leaks through.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
// Shared constants for the system control register bank.
// Assumes a 32-bit data path and 4-bit register/CRm fields.
package sysctl_pkg;
    localparam int WORD_W   = 32;
    localparam int REG_AW   = 4;
    localparam int CRM_W    = 4;
    localparam int OP_W     = 3;
    localparam int NDBG     = 4;
    localparam int ENDIAN_BIT = 7;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ID_VAL     = 32'h6905_2000;
    localparam word_t CACHE_VAL  = 32'h0B1A_A1AA;
    localparam word_t CTRL_RST   = 32'h0000_0078;
    localparam word_t CTRL_KEEP  = 32'h0000_3B87;
    localparam word_t CTRL_ONES  = 32'h0000_0078;
    localparam word_t AUX_KEEP   = 32'h0000_0033;
    localparam word_t TTB_KEEP   = 32'hFFFF_C000;
    localparam word_t FSR_KEEP   = 32'h0000_06FF;
    localparam word_t DLOCK_KEEP = 32'h0000_0001;
    localparam word_t PID_KEEP   = 32'hFE00_0000;
    localparam word_t CPACC_KEEP = 32'h0000_3FFF;

    // CRm code of each debug register inside CRn 14
    localparam logic [CRM_W-1:0] DBG_CRM [NDBG] = '{4'd3, 4'd4, 4'd8, 4'd9};
endpackage

// File: rtl/sysctl_legal.sv
`timescale 1ns/1ps
// Legality checker: decides whether a command may touch the bank.
// Purely combinational; assumes the caller gates it with the handshake.
module sysctl_legal
    import sysctl_pkg::*;
(
    input  logic              priv,
    input  logic [REG_AW-1:0] crn,
    input  logic [CRM_W-1:0]  crm,
    input  logic [OP_W-1:0]   op1,
    input  logic [OP_W-1:0]   op2,
    output logic              legal
);
    logic crm0, op20, reg_ok, pair7_ok;

    assign crm0 = (crm == '0);
    assign op20 = (op2 == '0);

    // Register 7 pair table (op2, CRm)
    always_comb begin
        unique case (op2)
            3'd0:    pair7_ok = (crm >= 4'd5) && (crm <= 4'd7);
            3'd1:    pair7_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
            3'd4:    pair7_ok = (crm == 4'd10);
            3'd5:    pair7_ok = (crm == 4'd2);
            3'd6:    pair7_ok = (crm == 4'd5);
            default: pair7_ok = 1'b0;
        endcase
    end

    // Per-register field rules
    always_comb begin
        case (crn)
            4'd0, 4'd1:                   reg_ok = crm0;
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13: reg_ok = crm0 && op20;
            4'd7:                         reg_ok = pair7_ok;
            4'd8:   reg_ok = (op20 && crm >= 4'd5 && crm <= 4'd7) ||
                             (op2 == 3'd1 && (crm == 4'd5 || crm == 4'd6));
            4'd9, 4'd10: reg_ok = (crm <= 4'd1) && (op2 <= 3'd1);
            4'd14:  reg_ok = op20 && (crm0 || crm == 4'd3 || crm == 4'd4 ||
                                      crm == 4'd8 || crm == 4'd9);
            4'd15:  reg_ok = op20 && (crm == 4'd1);
            default: reg_ok = 1'b0;
        endcase
    end

    assign legal = priv && (op1 == '0) && reg_ok;
endmodule

// File: rtl/sysctl_dbg_bank.sv
`timescale 1ns/1ps
// Debug register bank inside CRn 14: one fully writable word per CRm code.
// Assumes the parent qualifies 'we' with legality, CRn 14 and op2 = 0.
module sysctl_dbg_bank
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CRM_W-1:0] crm,
    input  word_t            wdata,
    output logic             hit,
    output word_t            rdata
);
    word_t            q   [NDBG];
    logic [NDBG-1:0]  sel;

    for (genvar g = 0; g < NDBG; g++) begin : g_dbg
        assign sel[g] = (crm == DBG_CRM[g]);

        // Store one debug word when its CRm code is written
        always_ff @(posedge clk) begin
            if (!rst_n)            q[g] <= '0;
            else if (we && sel[g]) q[g] <= wdata;
        end

        // R8: a debug word only changes when its own code is written
        a_r8_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel[g]) |=> $stable(q[g]));
    end

    // Select the addressed debug word for reads
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NDBG; i++)
            if (sel[i]) rdata = q[i];
    end

    assign hit = |sel;
endmodule

// File: rtl/sysctl_regbank.sv
`timescale 1ns/1ps
// System control register bank top: handshake, write masking, read mux and
// endianness side-band. Assumes one command per cycle, response same cycle.
module sysctl_regbank
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_priv,
    input  logic [REG_AW-1:0] cmd_crn,
    input  logic [CRM_W-1:0]  cmd_crm,
    input  logic [OP_W-1:0]   cmd_op1,
    input  logic [OP_W-1:0]   cmd_op2,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_ok,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              big_endian,
    output logic              mode_pulse
);
    logic  legal, fire, do_wr, set_b, wr_a, dbg_hit;
    word_t rd_val, dbg_rd;
    word_t ctrl_q, ttb_q, dac_q, fsr_q, far_q, dlock_q, pid_q, cpacc_q, r14_q, aux_q;
    logic  ready_q, pulse_q;

    sysctl_legal u_legal (
        .priv (cmd_priv), .crn (cmd_crn), .crm (cmd_crm),
        .op1  (cmd_op1),  .op2 (cmd_op2), .legal (legal)
    );

    assign fire  = cmd_valid && ready_q;
    assign rsp_ok = fire && legal;
    assign do_wr = rsp_ok && cmd_write;
    assign set_b = (cmd_op2 != '0);
    assign wr_a  = do_wr && !set_b;

    sysctl_dbg_bank u_dbg (
        .clk (clk), .rst_n (rst_n),
        .we  (wr_a && cmd_crn == 4'd14),
        .crm (cmd_crm), .wdata (cmd_wdata),
        .hit (dbg_hit), .rdata (dbg_rd)
    );

    // Ready rises on the first clock after reset
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Masked writes into the opcode_2 = 0 register set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            ttb_q   <= '0;
            dac_q   <= '0;
            fsr_q   <= '0;
            far_q   <= '0;
            dlock_q <= '0;
            pid_q   <= '0;
            cpacc_q <= '0;
            r14_q   <= '0;
        end else if (wr_a) begin
            case (cmd_crn)
                4'd1:  ctrl_q  <= (cmd_wdata & CTRL_KEEP) | CTRL_ONES;
                4'd2:  ttb_q   <= cmd_wdata & TTB_KEEP;
                4'd3:  dac_q   <= cmd_wdata;
                4'd5:  fsr_q   <= cmd_wdata & FSR_KEEP;
                4'd6:  far_q   <= cmd_wdata;
                4'd9:  dlock_q <= cmd_wdata & DLOCK_KEEP;
                4'd13: pid_q   <= cmd_wdata & PID_KEEP;
                4'd14: if (cmd_crm == '0) r14_q <= cmd_wdata;
                4'd15: cpacc_q <= cmd_wdata & CPACC_KEEP;
                default: ;
            endcase
        end
    end

    // Auxiliary control in the opcode_2 != 0 set
    always_ff @(posedge clk) begin
        if (!rst_n)                              aux_q <= '0;
        else if (do_wr && set_b && cmd_crn == 4'd1) aux_q <= cmd_wdata & AUX_KEEP;
    end

    // Change-mode pulse when a control write flips the endianness bit
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= wr_a && (cmd_crn == 4'd1) &&
                               (cmd_wdata[ENDIAN_BIT] != ctrl_q[ENDIAN_BIT]);
    end

    // Read mux over both register sets
    always_comb begin
        rd_val = '0;
        if (set_b) begin
            case (cmd_crn)
                4'd0:    rd_val = CACHE_VAL;
                4'd1:    rd_val = aux_q;
                default: rd_val = '0;
            endcase
        end else begin
            case (cmd_crn)
                4'd0:    rd_val = ID_VAL;
                4'd1:    rd_val = ctrl_q;
                4'd2:    rd_val = ttb_q;
                4'd3:    rd_val = dac_q;
                4'd5:    rd_val = fsr_q;
                4'd6:    rd_val = far_q;
                4'd9:    rd_val = dlock_q;
                4'd13:   rd_val = pid_q;
                4'd14:   rd_val = dbg_hit ? dbg_rd : r14_q;
                4'd15:   rd_val = cpacc_q;
                default: rd_val = '0;
            endcase
        end
    end

    assign rsp_rdata  = (rsp_ok && !cmd_write) ? rd_val : '0;
    assign cmd_ready  = ready_q;
    assign big_endian = ctrl_q[ENDIAN_BIT];
    assign mode_pulse = pulse_q;

    // R1: user mode never gets an accept
    a_r1_user_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_priv) |-> !rsp_ok);
    // R10: a rejected command returns zero data
    a_r10_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !legal) |-> (rsp_rdata == '0));
    // R10: a rejected command leaves control and auxiliary state alone
    a_r10_reject_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !legal) |=> ($stable(ctrl_q) && $stable(aux_q)));
    // R5: control bits 6:3 always read as one
    a_r5_ctrl_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[6:3] == 4'hF);
    // R6: a pulse always accompanies a real endianness change
    a_r6_pulse_change: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pulse |-> (big_endian != $past(big_endian)));
endmodule

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_priv = 1'b0;
    logic [3:0]  cmd_crn = '0, cmd_crm = '0;
    logic [2:0]  cmd_op1 = '0, cmd_op2 = '0;
    logic [31:0] cmd_wdata = '0;
    logic        cmd_ready, rsp_ok, big_endian, mode_pulse;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference state
    logic [31:0] m_a   [16];
    logic [31:0] m_dbg [16];
    logic [31:0] m_aux;
    logic        m_pulse;

    always #2.5 clk = ~clk;

    sysctl_regbank u0 (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_write (cmd_write),
        .cmd_priv (cmd_priv), .cmd_crn (cmd_crn), .cmd_crm (cmd_crm),
        .cmd_op1 (cmd_op1), .cmd_op2 (cmd_op2), .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready), .rsp_ok (rsp_ok), .rsp_rdata (rsp_rdata),
        .big_endian (big_endian), .mode_pulse (mode_pulse)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_legal(bit pv, int n, int m, int o1, int o2);
        int pairs7 [9][2] = '{'{0,5},'{0,6},'{0,7},'{1,5},'{1,6},'{1,10},'{4,10},'{5,2},'{6,5}};
        if (!pv || o1 != 0) return 0;
        case (n)
            0, 1:             return m == 0;
            2, 3, 5, 6, 13:   return m == 0 && o2 == 0;
            7: begin
                foreach (pairs7[i]) if (pairs7[i][0] == o2 && pairs7[i][1] == m) return 1;
                return 0;
            end
            8:      return (o2 == 0 && m >= 5 && m <= 7) || (o2 == 1 && (m == 5 || m == 6));
            9, 10:  return m <= 1 && o2 <= 1;
            14:     return o2 == 0 && (m inside {0, 3, 4, 8, 9});
            15:     return o2 == 0 && m == 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(int n, int m, int o2);
        if (o2 != 0) return (n == 0) ? 32'h0B1AA1AA : (n == 1) ? m_aux : 32'h0;
        if (n == 0) return 32'h69052000;
        if (n == 14 && (m inside {3, 4, 8, 9})) return m_dbg[m];
        return m_a[n];
    endfunction

    task automatic m_write(int n, int m, int o2, logic [31:0] d);
        logic [31:0] nv;
        if (o2 != 0) begin
            if (n == 1) m_aux = d & 32'h33;
            return;
        end
        case (n)
            1: begin
                nv = (d & 32'h3B87) | 32'h78;
                m_pulse = (nv[7] != m_a[1][7]);
                m_a[1] = nv;
            end
            2:  m_a[2]  = d & 32'hFFFFC000;
            3:  m_a[3]  = d;
            5:  m_a[5]  = d & 32'h6FF;
            6:  m_a[6]  = d;
            9:  m_a[9]  = d & 32'h1;
            13: m_a[13] = d & 32'hFE000000;
            14: if (m == 0) m_a[14] = d; else m_dbg[m] = d;
            15: m_a[15] = d & 32'h3FFF;
            default: ;
        endcase
    endtask

    // One command: compare the same-cycle response, then the side-band after the edge
    task automatic cmd(string tag, bit w, bit pv, int n, int m, int o1, int o2, logic [31:0] d);
        bit exp_ok;
        logic [31:0] exp_rd;
        @(negedge clk);
        cmd_valid = 1; cmd_write = w; cmd_priv = pv;
        cmd_crn = 4'(n); cmd_crm = 4'(m); cmd_op1 = 3'(o1); cmd_op2 = 3'(o2); cmd_wdata = d;
        #1;
        exp_ok = m_legal(pv, n, m, o1, o2);
        exp_rd = (exp_ok && !w) ? m_read(n, m, o2) : 32'h0;
        chk({tag, " ok"}, 32'(rsp_ok), 32'(exp_ok));
        chk({tag, " data"}, rsp_rdata, exp_rd);
        m_pulse = 0;
        if (exp_ok && w) m_write(n, m, o2, d);
        @(posedge clk); #1;
        cmd_valid = 0;
        chk("R6 endian", 32'(big_endian), 32'(m_a[1][7]));
        chk("R6 pulse", 32'(mode_pulse), 32'(m_pulse));
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        foreach (m_a[i])   m_a[i] = '0;
        foreach (m_dbg[i]) m_dbg[i] = '0;
        m_a[1] = 32'h78; m_aux = '0; m_pulse = 0;

        repeat (3) @(posedge clk);
        #1 chk("R9 ready in reset", 32'(cmd_ready), 32'h0);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1;
        chk("R9 ready after reset", 32'(cmd_ready), 32'h1);
        chk("R6 endian reset", 32'(big_endian), 32'h0);

        // R5 control register reset and masking, R6 pulse rules
        cmd("R5", 0, 1, 1, 0, 0, 0, 0);
        cmd("R5", 1, 1, 1, 0, 0, 0, 32'hFFFFFFFF);
        cmd("R5", 0, 1, 1, 0, 0, 0, 0);
        cmd("R6 same", 1, 1, 1, 0, 0, 0, 32'hFFFFFF80);
        cmd("R6 back", 1, 1, 1, 0, 0, 0, 32'h0);
        cmd("R5", 0, 1, 1, 0, 0, 0, 0);

        // R4 constants ignore writes
        cmd("R4", 0, 1, 0, 0, 0, 0, 0);
        cmd("R4", 1, 1, 0, 0, 0, 0, 32'h12345678);
        cmd("R4", 0, 1, 0, 0, 0, 0, 0);
        cmd("R4", 0, 1, 0, 0, 0, 3, 0);
        cmd("R4", 1, 1, 0, 0, 0, 3, 32'hFFFFFFFF);
        cmd("R4", 0, 1, 0, 0, 0, 3, 0);

        // R1 user mode and non-zero op1 rejected; R10 no state change
        cmd("R1", 1, 0, 1, 0, 0, 0, 32'hFFFFFFFF);
        cmd("R1", 0, 0, 3, 0, 0, 0, 0);
        cmd("R1", 1, 1, 3, 0, 2, 0, 32'hFFFFFFFF);
        cmd("R10", 0, 1, 3, 0, 0, 0, 0);
        cmd("R10", 1, 1, 2, 1, 0, 0, 32'hFFFFFFFF);
        cmd("R10", 0, 1, 2, 0, 0, 0, 0);

        // R7 masks and discarded registers
        foreach (m_a[i]) begin
            int m = (i == 15) ? 1 : (i == 7 || i == 8) ? 5 : 0;
            cmd("R7 wr", 1, 1, i, m, 0, 0, 32'hFFFFFFFF);
            cmd("R7 rd", 0, 1, i, m, 0, 0, 0);
        end

        // R11 auxiliary set
        cmd("R11", 1, 1, 1, 0, 0, 2, 32'hFFFFFFFF);
        cmd("R11", 0, 1, 1, 0, 0, 5, 0);
        cmd("R11", 1, 1, 9, 1, 0, 1, 32'hFFFFFFFF);
        cmd("R11", 0, 1, 9, 1, 0, 1, 0);

        // R8 debug registers and shared slot
        foreach (m_a[i]) if (i inside {0, 3, 4, 8, 9})
            cmd("R8 wr", 1, 1, 14, i, 0, 0, 32'hA0000000 + 32'(i * 32'h111));
        foreach (m_a[i]) if (i inside {0, 3, 4, 8, 9})
            cmd("R8 rd", 0, 1, 14, i, 0, 0, 0);

        // legality sweep with R9 same-cycle read data
        for (int n = 0; n < 16; n++)
            for (int m = 0; m < 16; m++)
                for (int o = 0; o < 8; o++)
                    cmd(n == 7 ? "R3 sweep" : n == 14 ? "R8 sweep" :
                        o != 0 ? "R11 sweep" : "R2 sweep", 0, 1, n, m, 0, o, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule